// File: doc/BRIEF.md
# Flash Status Read Port with Byte-Wide Mode

This block is the device-side command front end of a serial flash part. It watches the serial clock, the active-low chip select and the serial data input, and collects an 8-bit instruction. It answers one instruction, the status read, by streaming a status byte back to the host. The byte itself comes from the rest of the device on a plain input. A sticky byte-wide flag picks how the byte leaves. When the flag is clear, the byte goes out one bit per serial clock on a single output pin. When the flag is set, the whole byte goes out on every serial clock over an 8-bit output bus. Two instructions of their own set and clear the flag. The flag survives chip-select cycles and is cleared only by its clear instruction or by power-on reset.

A fast system clock `clk` samples SCK, CS# and SI, and edges of SCK are found from those samples. Instruction bits are taken on rising SCK edges and output data changes on falling SCK edges, so both SPI mode 0 and mode 3 work. Each output carries its own enable. While the enable is low the pin is high impedance, and the value on it means nothing. The host paces the stream with SCK and CS#. There is no valid/ready handshake and no back-pressure. `stat_i` is a plain level that is sampled when a byte begins.

Top module: `flash_status_port`

## Requirements
- R1: After `rst_n` is low, both enables `so_oe` and `po_oe` are 0 and the byte-wide flag is clear, so a following status read comes out bit-serially.
- R2: The instruction is taken MSB first on the first eight rising SCK edges after CS# falls. While it is being taken, `so_oe` and `po_oe` stay 0.
- R3: With the flag clear, instruction 0x05 starts a serial stream. From the first falling SCK edge after the eighth rising edge, `so_o` presents one status bit per falling edge, bit 7 first, with `so_oe`=1 and `po_oe`=0.
- R4: The serial stream repeats the status byte every eight falling edges for as long as CS# stays low. `stat_i` is captured at the first bit of each byte, so a change in mid-byte shows up only in the next byte.
- R5: Instruction 0x55 sets the byte-wide flag and instruction 0x45 clears it. The flag holds across later chip-select cycles and instructions.
- R6: With the flag set, instruction 0x05 drives `po_o` with the current `stat_i` on every falling SCK edge, with `po_oe`=1 and `so_oe`=0. In this mode, rising SCK edges must be at least `PAR_SCK_MIN_CLKS` `clk` cycles apart.
- R7: Raising CS# ends any command at the next `clk` edge. Both enables drop, the bit count restarts and the flag keeps its value. If CS# rises in the same cycle as a falling SCK edge, deselect wins.
- R8: Any opcode other than 0x05, 0x55 and 0x45 is ignored. This includes the bit-reversed read opcode 0xA0. Both enables stay 0 until CS# rises, and the flag is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low power-on reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial instruction input |
| stat_i | input | 8 | Status byte from the device core |
| so_o | output | 1 | Serial status bit |
| so_oe | output | 1 | Enable for `so_o` (0 = high impedance) |
| po_o | output | 8 | Byte-wide status bus |
| po_oe | output | 1 | Enable for `po_o` (0 = high impedance) |

## Verification
Deselect and stream advance can land in the same `clk` cycle. This happens when CS# rises in the sample where a falling SCK edge would otherwise drive the next byte. The bench provokes it by changing `sck` and `cs_n` on the same drive edge in the middle of a byte-wide stream. It then judges that both enables are low one cycle later. It also judges that the next status read still comes out byte-wide, which shows the flag was kept.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int OP_W   = 8;
  localparam int STAT_W = 8;

  localparam logic [OP_W-1:0] OPC_STAT_RD = 8'h05;
  localparam logic [OP_W-1:0] OPC_WIDE_ON = 8'h55;
  localparam logic [OP_W-1:0] OPC_WIDE_OFF = 8'h45;

  typedef enum logic [1:0] {
    PH_OPCODE = 2'd0,
    PH_STREAM = 2'd1,
    PH_SINK   = 2'd2
  } phase_t;
endpackage

// File: rtl/fsp_edge_det.sv
module fsp_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  output logic sck_rise,
  output logic sck_fall
);
  logic sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  assign sck_rise = sck & ~sck_q;
  assign sck_fall = ~sck & sck_q;
endmodule

// File: rtl/fsp_cmd_rx.sv
module fsp_cmd_rx
  import fsp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck_rise,
  input  logic si,
  output logic wide_mode,
  output logic stream_act,
  output logic op_busy
);
  localparam int CW = $clog2(OP_W);

  phase_t          ph;
  logic [CW-1:0]   cnt;
  logic [OP_W-2:0] sh;
  logic [OP_W-1:0] opc;

  assign opc = {sh, si};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_OPCODE;
      cnt       <= '0;
      sh        <= '0;
      wide_mode <= 1'b0;
    end else if (cs_n) begin
      ph  <= PH_OPCODE;
      cnt <= '0;
      sh  <= '0;
    end else if (sck_rise && ph == PH_OPCODE) begin
      sh  <= opc[OP_W-2:0];
      cnt <= cnt + 1'b1;
      if (cnt == CW'(OP_W-1)) begin
        cnt <= '0;
        case (opc)
          OPC_STAT_RD: ph <= PH_STREAM;
          OPC_WIDE_ON: begin
            wide_mode <= 1'b1;
            ph        <= PH_SINK;
          end
          OPC_WIDE_OFF: begin
            wide_mode <= 1'b0;
            ph        <= PH_SINK;
          end
          default: ph <= PH_SINK;
        endcase
      end
    end
  end

  assign stream_act = (ph == PH_STREAM);
  assign op_busy    = (ph == PH_OPCODE);

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(wide_mode)); // R7
endmodule

// File: rtl/fsp_stat_tx.sv
module fsp_stat_tx
  import fsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              stream_act,
  input  logic              wide_mode,
  input  logic              sck_fall,
  input  logic [STAT_W-1:0] stat_i,
  output logic              so_o,
  output logic              so_oe,
  output logic [STAT_W-1:0] po_o,
  output logic              po_oe
);
  localparam int IW = $clog2(STAT_W);

  logic [IW-1:0]     idx;
  logic [STAT_W-2:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      sh    <= '0;
      so_o  <= 1'b0;
      so_oe <= 1'b0;
      po_o  <= '0;
      po_oe <= 1'b0;
    end else if (cs_n || !stream_act) begin
      idx   <= '0;
      so_oe <= 1'b0;
      po_oe <= 1'b0;
    end else if (sck_fall) begin
      if (wide_mode) begin
        po_o  <= stat_i;
        po_oe <= 1'b1;
      end else begin
        so_oe <= 1'b1;
        idx   <= (idx == IW'(STAT_W-1)) ? '0 : idx + 1'b1;
        if (idx == '0) begin
          so_o <= stat_i[STAT_W-1];
          sh   <= stat_i[STAT_W-2:0];
        end else begin
          so_o <= sh[STAT_W-2];
          sh   <= {sh[STAT_W-3:0], 1'b0};
        end
      end
    end
  end

  AST_SER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && stream_act && !cs_n && !wide_mode && idx == '0)
      |=> (so_o == $past(stat_i[STAT_W-1]))); // R4
endmodule

// File: rtl/flash_status_port.sv
module flash_status_port
  import fsp_pkg::*;
#(
  parameter int PAR_SCK_MIN_CLKS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic [STAT_W-1:0] stat_i,
  output logic              so_o,
  output logic              so_oe,
  output logic [STAT_W-1:0] po_o,
  output logic              po_oe
);
  localparam int GW = $clog2(PAR_SCK_MIN_CLKS + 1);

  logic sck_rise, sck_fall;
  logic wide_mode, stream_act, op_busy;
  logic [GW-1:0] gap;

  fsp_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .sck(sck),
    .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  fsp_cmd_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise), .si(si),
    .wide_mode(wide_mode), .stream_act(stream_act), .op_busy(op_busy)
  );

  fsp_stat_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .stream_act(stream_act),
    .wide_mode(wide_mode), .sck_fall(sck_fall), .stat_i(stat_i),
    .so_o(so_o), .so_oe(so_oe), .po_o(po_o), .po_oe(po_oe)
  );

  // clk cycles since the last rising SCK edge, saturating; checks the wide-mode rate limit
  always_ff @(posedge clk) begin
    if (!rst_n || cs_n)                     gap <= GW'(PAR_SCK_MIN_CLKS);
    else if (sck_rise)                      gap <= '0;
    else if (gap != GW'(PAR_SCK_MIN_CLKS))  gap <= gap + 1'b1;
  end

  AST_SCK_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && wide_mode && !cs_n) |-> (gap >= GW'(PAR_SCK_MIN_CLKS - 1))); // R6

  AST_QUIET_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && !cs_n) |-> (!so_oe && !po_oe)); // R2

  AST_SER_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> !wide_mode); // R3

  AST_WIDE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    po_oe |-> wide_mode); // R6

  AST_DESELECT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!so_oe && !po_oe)); // R7
endmodule

// File: tb/flash_status_port_test.sv
`timescale 1ns/100ps
module flash_status_port_test;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic [7:0] stat_i = 8'h00;
  logic so_o, so_oe, po_oe;
  logic [7:0] po_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_status_port uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .stat_i(stat_i), .so_o(so_o), .so_oe(so_oe), .po_o(po_o), .po_oe(po_oe)
  );

  // fields: [17:10] opcode, [9:2] status, [1] wide flag, [0] start SCK high (mode 3)
  localparam logic [17:0] VECS [0:7] = '{
    {8'h05, 8'hA5, 1'b0, 1'b0},
    {8'h05, 8'h3C, 1'b0, 1'b1},
    {8'h05, 8'h81, 1'b1, 1'b0},
    {8'h05, 8'h7E, 1'b1, 1'b1},
    {8'h9F, 8'hFF, 1'b0, 1'b0},
    {8'h04, 8'h55, 1'b1, 1'b1},
    {8'h05, 8'h00, 1'b1, 1'b0},
    {8'hA0, 8'hF0, 1'b0, 1'b1}
  };

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame_open(input logic m3);
    sck = m3;
    wait_clks(4);
    cs_n = 1'b0;
    wait_clks(H);
  endtask

  task automatic frame_close(input logic m3);
    sck = m3;
    wait_clks(2);
    cs_n = 1'b1;
    wait_clks(4);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0;
      si = b[i];
      wait_clks(H);
      check("R2 quiet during opcode", {7'd0, so_oe, po_oe}, 9'd0);
      sck = 1'b1;
      wait_clks(H);
    end
  endtask

  task automatic fall_edge();
    sck = 1'b0;
    wait_clks(H);
  endtask

  task automatic rise_edge();
    sck = 1'b1;
    wait_clks(H);
  endtask

  task automatic command(input logic [7:0] op, input logic m3);
    frame_open(m3);
    send_bits(op, 8);
    frame_close(m3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] cap;
    wait_clks(5);
    // R1: enables low during and after reset
    check("R1 oe in reset", {7'd0, so_oe, po_oe}, 9'd0);
    rst_n = 1'b1;
    wait_clks(3);
    check("R1 oe after reset", {7'd0, so_oe, po_oe}, 9'd0);

    // vector table walk: R3 R5 R6 R8, with R2 checked during each opcode
    for (int v = 0; v < 8; v++) begin
      logic [7:0] op, st;
      logic wide, m3, rd;
      op = VECS[v][17:10];
      st = VECS[v][9:2];
      wide = VECS[v][1];
      m3 = VECS[v][0];
      rd = (op == 8'h05);
      command(wide ? 8'h55 : 8'h45, m3);
      stat_i = st;
      frame_open(m3);
      send_bits(op, 8);
      for (int i = 0; i < 16; i++) begin
        fall_edge();
        if (rd && !wide) begin
          check("R3 serial enables", {7'd0, so_oe, po_oe}, 9'b10);
          check("R3 R4 serial bit", {8'd0, so_o}, {8'd0, st[7 - (i % 8)]});
        end else if (rd && wide) begin
          check("R5 R6 wide enables", {7'd0, so_oe, po_oe}, 9'b01);
          check("R6 wide byte", {1'b0, po_o}, {1'b0, st});
        end else begin
          check("R8 ignored opcode", {7'd0, so_oe, po_oe}, 9'd0);
        end
        rise_edge();
      end
      frame_close(m3);
    end

    // R8: ignored opcode leaves the wide flag set
    command(8'h55, 1'b0);
    command(8'h3B, 1'b0);
    stat_i = 8'h5A;
    frame_open(1'b0);
    send_bits(8'h05, 8);
    fall_edge();
    check("R8 flag kept after unknown opcode", {po_oe, po_o}, {1'b1, 8'h5A});
    rise_edge();
    frame_close(1'b0);

    // R1: reset clears the flag
    command(8'h55, 1'b1);
    rst_n = 1'b0;
    wait_clks(4);
    rst_n = 1'b1;
    wait_clks(2);
    stat_i = 8'hC3;
    frame_open(1'b1);
    send_bits(8'h05, 8);
    fall_edge();
    check("R1 serial after reset", {7'd0, so_oe, po_oe}, 9'b10);
    check("R1 first bit", {8'd0, so_o}, 9'd1);
    rise_edge();
    frame_close(1'b1);

    // R4: status change in mid-byte waits for the next byte
    stat_i = 8'hF0;
    frame_open(1'b0);
    send_bits(8'h05, 8);
    cap = 8'hF0;
    for (int i = 0; i < 16; i++) begin
      fall_edge();
      if (i == 8) cap = 8'h0F;
      check("R4 byte-start capture", {8'd0, so_o}, {8'd0, cap[7 - (i % 8)]});
      if (i == 2) stat_i = 8'h0F;
      rise_edge();
    end
    frame_close(1'b0);

    // R6: wide mode follows stat_i on every edge
    command(8'h55, 1'b0);
    stat_i = 8'h11;
    frame_open(1'b0);
    send_bits(8'h05, 8);
    fall_edge();
    check("R6 wide first", {1'b0, po_o}, {1'b0, 8'h11});
    rise_edge();
    stat_i = 8'h22;
    fall_edge();
    check("R6 wide follows", {1'b0, po_o}, {1'b0, 8'h22});
    rise_edge();
    // R7: deselect in the same cycle as a falling edge
    stat_i = 8'h33;
    sck = 1'b0;
    cs_n = 1'b1;
    wait_clks(2);
    check("R7 deselect wins", {7'd0, so_oe, po_oe}, 9'd0);
    wait_clks(4);
    frame_open(1'b0);
    send_bits(8'h05, 8);
    fall_edge();
    check("R7 flag kept", {po_oe, po_o}, {1'b1, 8'h33});
    rise_edge();
    frame_close(1'b0);

    // R7: abort mid-opcode restarts the bit count and leaves the flag
    command(8'h45, 1'b0);
    frame_open(1'b0);
    send_bits(8'h55, 4);
    cs_n = 1'b1;
    wait_clks(2);
    check("R7 abort oe", {7'd0, so_oe, po_oe}, 9'd0);
    wait_clks(4);
    stat_i = 8'h80;
    frame_open(1'b0);
    send_bits(8'h05, 8);
    fall_edge();
    check("R7 count restarted", {7'd0, so_oe, po_oe}, 9'b10);
    check("R7 bit after abort", {8'd0, so_o}, 9'd1);
    rise_edge();
    frame_close(1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule